// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block repairs a 512-byte data sector after a Reed-Solomon decoder has found its errors. The sector sits in a byte-wide buffer inside the block. While the block is idle, a host port loads that buffer and reads it back. The decoder's symbols are 9 bits wide and are packed across byte boundaries. Each error report therefore gives a 1-based symbol index and a 9-bit flip mask, and a correction can reach into two neighbouring bytes.

A pulse on `start` latches up to four reports and an error count. The block then works through the reports in slot order. For each report it reads the target byte, XORs in the low part of the shifted mask and writes the byte back. It does the same for the following byte with the high part of the mask. Each report takes exactly four cycles, whether or not it writes anything. When the last report is done, `done` pulses for one cycle. The host reads the repaired sector afterwards.

Top module: `rs_sym_fixer`

## Requirements
- R1: While `busy` is low, a high `host_we` writes `host_wdata` to byte `host_addr` at the clock edge. `host_rdata` shows the byte addressed at the previous clock edge, so a read has a latency of one cycle.
- R2: Slot j of a report takes its index from bits [10j+9:10j] of `rep_idx`. With z = index - 1, the target byte offset is z + floor(z/8).
- R3: Slot j takes its mask from bits [9j+8:9j] of `rep_mask`. The mask is shifted left by (z mod 8) into a 16-bit value, and bits 7:0 of that value are XORed into the target byte.
- R4: Bits 15:8 of the shifted mask are XORed into the byte that follows the target byte.
- R5: Reports are applied in slot order 0, 1, 2, 3. A report sees the bytes as earlier reports left them, so two reports that touch the same byte both take effect.
- R6: For an error count n from 1 to 4, only slots 0 to n-1 are applied, and the other slots have no effect on the sector.
- R7: A report whose target byte is 511 changes only byte 511. Its high mask bits are dropped, and byte 0 is left unchanged.
- R8: A report whose target offset is 512 or more leaves the sector unchanged. This includes index 0, which wraps to a large offset.
- R9: An error count of 0 or of 5 to 7 leaves the sector unchanged, and `done` pulses in the first cycle after the start edge.
- R10: With n reports applied, `busy` is high from the start edge until `done`. `done` is a one-cycle pulse in the cycle that follows the (4n)-th clock edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write enable (used only while idle) |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Buffer read data, one cycle after the address |
| start | input | 1 | Latch the reports and count, and begin applying them |
| err_cnt | input | 3 | Number of valid report slots |
| rep_idx | input | 40 | Four 10-bit 1-based symbol indices, slot 0 in the low bits |
| rep_mask | input | 36 | Four 9-bit error masks, slot 0 in the low bits |
| busy | output | 1 | Corrections in progress |
| done | output | 1 | One-cycle pulse when all reports have been applied |

## Verification
The sector is loaded with a different byte pattern for each scenario, so a write to the wrong byte or with the wrong mask half shows up in a full readback. A single report in mid-sector tells apart the index-to-offset mapping and the split of the mask into its low and high parts. Four reports with overlapping bytes show whether the slots are applied in order and whether their effects accumulate. The other scenarios each target one corner: a count below the number of filled slots, the last byte of the sector, offsets past the end, index 0, and counts outside 1 to 4. The cycle count to `done` is checked in every run.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;

    parameter int SECT_BYTES = 512;
    parameter int BYTE_AW    = $clog2(SECT_BYTES);
    parameter int IDX_W      = 10;
    parameter int MASK_W     = 9;
    parameter int MAX_REPS   = 4;
    parameter int CNT_W      = 3;
    parameter int SLOT_W     = $clog2(MAX_REPS);
    parameter int SH_W       = MASK_W + 7;
    parameter int OFF_W      = IDX_W + 1;

    typedef struct packed {
        logic               hit;
        logic               spill;
        logic [BYTE_AW-1:0] addr;
        logic [7:0]         lo_mask;
        logic [7:0]         hi_mask;
    } target_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_WR_LO,
        ST_RD_HI,
        ST_WR_HI,
        ST_FIN
    } fix_state_t;

    function automatic target_t rs_target(input logic [IDX_W-1:0]  idx,
                                          input logic [MASK_W-1:0] mask);
        logic [IDX_W-1:0] z;
        logic [OFF_W-1:0] off;
        logic [SH_W-1:0]  sh;
        target_t          t;
        z         = idx - 1'b1;
        off       = {1'b0, z} + ({1'b0, z} >> 3);
        sh        = SH_W'(mask) << z[2:0];
        t.hit     = off < OFF_W'(SECT_BYTES);
        t.spill   = t.hit && (off != OFF_W'(SECT_BYTES - 1));
        t.addr    = off[BYTE_AW-1:0];
        t.lo_mask = sh[7:0];
        t.hi_mask = sh[15:8];
        return t;
    endfunction

endpackage

// File: rtl/rsf_sector_ram.sv
module rsf_sector_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/rsf_report_decode.sv
module rsf_report_decode
    import rs_fix_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [MASK_W-1:0] mask,
    output target_t           tgt
);
    always_comb tgt = rs_target(idx, mask);
endmodule

// File: rtl/rsf_fix_seq.sv
module rsf_fix_seq
    import rs_fix_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [CNT_W-1:0]            err_cnt,
    input  target_t [MAX_REPS-1:0]      tgt_in,
    input  logic [7:0]                  rdata,
    output logic                        eng_we,
    output logic [BYTE_AW-1:0]          eng_addr,
    output logic [7:0]                  eng_wdata,
    output logic                        busy,
    output logic                        done
);
    fix_state_t             state_q;
    logic [SLOT_W-1:0]      slot_q;
    logic [SLOT_W-1:0]      last_q;
    target_t [MAX_REPS-1:0] tgt_q;
    target_t                cur;
    logic                   cnt_ok;

    assign cnt_ok = (err_cnt != '0) && (err_cnt <= CNT_W'(MAX_REPS));
    assign cur    = tgt_q[slot_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            last_q  <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    tgt_q   <= tgt_in;
                    slot_q  <= '0;
                    last_q  <= SLOT_W'(err_cnt - 1'b1);
                    state_q <= cnt_ok ? ST_RD_LO : ST_FIN;
                end
                ST_RD_LO: state_q <= ST_WR_LO;
                ST_WR_LO: state_q <= ST_RD_HI;
                ST_RD_HI: state_q <= ST_WR_HI;
                ST_WR_HI: begin
                    if (slot_q == last_q) begin
                        state_q <= ST_FIN;
                    end else begin
                        slot_q  <= slot_q + 1'b1;
                        state_q <= ST_RD_LO;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_addr  = cur.addr;
        eng_we    = 1'b0;
        eng_wdata = rdata ^ cur.lo_mask;
        case (state_q)
            ST_WR_LO: eng_we = cur.hit;
            ST_RD_HI: eng_addr = cur.addr + 1'b1;
            ST_WR_HI: begin
                eng_addr  = cur.addr + 1'b1;
                eng_we    = cur.spill;
                eng_wdata = rdata ^ cur.hi_mask;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FIN);

    // R10: done lasts exactly one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a count outside 1..4 finishes at once
    p_bad_cnt_done_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !cnt_ok) |=> done);

    // R10: a valid count keeps the block busy and not done in the next cycle
    p_good_cnt_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && cnt_ok) |=> (busy && !done));

    // R3: every write-back goes to the byte read in the cycle before it
    p_rmw_same_addr_r3: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> (eng_addr == $past(eng_addr)));

    // R4: the high-half write lands on the byte right after the low-half byte
    p_hi_adjacent_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_HI) |-> (eng_addr == $past(eng_addr, 2) + 1'b1));
endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer
    import rs_fix_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         host_we,
    input  logic [BYTE_AW-1:0]           host_addr,
    input  logic [7:0]                   host_wdata,
    output logic [7:0]                   host_rdata,
    input  logic                         start,
    input  logic [CNT_W-1:0]             err_cnt,
    input  logic [MAX_REPS*IDX_W-1:0]    rep_idx,
    input  logic [MAX_REPS*MASK_W-1:0]   rep_mask,
    output logic                         busy,
    output logic                         done
);
    target_t [MAX_REPS-1:0] tgt;
    logic                   eng_we;
    logic [BYTE_AW-1:0]     eng_addr;
    logic [7:0]             eng_wdata;
    logic                   ram_we;
    logic [BYTE_AW-1:0]     ram_addr;
    logic [7:0]             ram_wdata;
    logic [7:0]             ram_rdata;

    for (genvar j = 0; j < MAX_REPS; j++) begin : g_dec
        rsf_report_decode u_dec (
            .idx  (rep_idx[j*IDX_W +: IDX_W]),
            .mask (rep_mask[j*MASK_W +: MASK_W]),
            .tgt  (tgt[j])
        );
    end

    rsf_fix_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .err_cnt   (err_cnt),
        .tgt_in    (tgt),
        .rdata     (ram_rdata),
        .eng_we    (eng_we),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .busy      (busy),
        .done      (done)
    );

    assign ram_we    = busy ? eng_we    : host_we;
    assign ram_addr  = busy ? eng_addr  : host_addr;
    assign ram_wdata = busy ? eng_wdata : host_wdata;

    rsf_sector_ram #(.DEPTH(SECT_BYTES)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign host_rdata = ram_rdata;

    // R1: the host cannot write while corrections are running
    p_host_blocked_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && ram_we) |-> eng_we);
endmodule

// File: tb/tb_rs_sym_fixer.sv
`timescale 1ns/1ps
module tb_rs_sym_fixer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        start = 1'b0;
    logic [2:0]  err_cnt = '0;
    logic [39:0] rep_idx = '0;
    logic [35:0] rep_mask = '0;
    logic        busy, done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [7:0] exp_mem [512];

    always #4 clk = ~clk;

    rs_sym_fixer dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start),
        .err_cnt(err_cnt), .rep_idx(rep_idx), .rep_mask(rep_mask),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int seed);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            exp_mem[i] = 8'(i * seed + 17);
            host_we    = 1'b1;
            host_addr  = 9'(i);
            host_wdata = exp_mem[i];
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic compare(input string req);
        int bad = 0, bad_a = 0, bad_v = 0, bad_e = 0;
        @(negedge clk);
        host_addr = 9'd0;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (host_rdata !== exp_mem[i]) begin
                if (bad == 0) begin
                    bad_a = i; bad_v = int'(host_rdata); bad_e = int'(exp_mem[i]);
                end
                bad++;
            end
            host_addr = 9'(i + 1);
        end
        chk(bad == 0, req, $sformatf("sector byte %0d", bad_a), bad_v, bad_e);
    endtask

    task automatic set_slot(input int j, input int idx, input int mask);
        rep_idx[j*10 +: 10] = 10'(idx);
        rep_mask[j*9 +: 9]  = 9'(mask);
    endtask

    // expected sector after a run, from R2..R8
    task automatic model(input int cnt);
        int n = (cnt >= 1 && cnt <= 4) ? cnt : 0;
        for (int j = 0; j < n; j++) begin
            int idx  = int'(rep_idx[j*10 +: 10]);
            int mask = int'(rep_mask[j*9 +: 9]);
            int z    = (idx + 1023) % 1024;
            int off  = z + z / 8;
            int sh   = mask << (z % 8);
            if (off < 512) begin
                exp_mem[off] ^= 8'(sh & 255);
                if (off < 511) exp_mem[off + 1] ^= 8'((sh >> 8) & 255);
            end
        end
    endtask

    task automatic fire(input int cnt, input string req);
        int n = (cnt >= 1 && cnt <= 4) ? cnt : 0;
        int cycles = 1;
        model(cnt);
        @(negedge clk);
        err_cnt = 3'(cnt);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10", "busy after start", int'(busy), 1);
        while (done !== 1'b1 && cycles < 40) begin
            @(negedge clk);
            cycles++;
        end
        chk(cycles == 4 * n + 1, req, "cycles to done", cycles, 4 * n + 1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R10", "done/busy after pulse",
            int'({busy, done}), 0);
    endtask

    task automatic t_reset();
        chk(done === 1'b0, "R10", "done at reset", int'(done), 0);
        chk(busy === 1'b0, "R10", "busy at reset", int'(busy), 0);
    endtask

    task automatic t_host_rw();
        load(3);
        compare("R1");
    endtask

    task automatic t_single();
        load(5);
        rep_idx = '0; rep_mask = '0;
        set_slot(0, 10, 'h1FF);           // target byte 10, lo FE, hi 03
        fire(1, "R10");
        compare("R2 R3 R4");
    endtask

    task automatic t_overlap();
        load(7);
        set_slot(0, 20, 'h1FF);           // bytes 21, 22
        set_slot(1, 21, 'h0F3);           // bytes 22, 23
        set_slot(2, 1,  'h155);           // bytes 0, 1
        set_slot(3, 300, 'h0AA);
        fire(4, "R10");
        compare("R5");
    endtask

    task automatic t_partial();
        load(11);
        set_slot(0, 50, 'h101);
        set_slot(1, 60, 'h0FF);
        set_slot(2, 70, 'h1FF);           // must not be applied
        set_slot(3, 80, 'h1FF);           // must not be applied
        fire(2, "R10");
        compare("R6");
    endtask

    task automatic t_last_byte();
        load(13);
        rep_idx = '0; rep_mask = '0;
        set_slot(0, 456, 'h1FF);          // z=455 -> byte 511, shift 7
        fire(1, "R10");
        compare("R7");
    endtask

    task automatic t_out_of_range();
        load(17);
        set_slot(0, 457, 'h1FF);          // offset 513
        set_slot(1, 0,   'h1FF);          // index 0 wraps
        set_slot(2, 1023, 'h1FF);
        set_slot(3, 500, 'h0FF);
        fire(4, "R10");
        compare("R8");
    endtask

    task automatic t_bad_count();
        load(19);
        set_slot(0, 10, 'h1FF);
        set_slot(1, 20, 'h1FF);
        fire(0, "R9");
        compare("R9");
        fire(5, "R9");
        compare("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_rw();
        t_single();
        t_overlap();
        t_partial();
        t_last_byte();
        t_out_of_range();
        t_bad_count();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule